// File: doc/BRIEF.md
# NAND ECC Geometry Calculator

A sequential arithmetic unit that turns a NAND page's data size and spare-area size into the layout of a chunked BCH protection scheme. It reports how many chunks a page holds, the correction strength per chunk, and where the factory bad-block marker byte ends up once the page is viewed as a logical data buffer. That last result is split into a byte offset and a bit position within the byte.

On the medium, each chunk's data is followed by that chunk's parity. The physical marker sits at a fixed place in the raw page, so in the data buffer it appears shifted back by all the parity bits stored before it. The unit finds the chunk that holds the marker, rejects a geometry where the marker falls inside a parity field, and removes the earlier parity bits from the offset.

A one-cycle start pulse latches the inputs. All three divisions run one after another on a single shared restoring divider. A one-cycle done pulse delivers the results, which then hold until the next computation completes.

Top module: `ecc_geom_calc`

## Requirements
- R1: When the spare size is above 512 bytes, the chunk is 1024 bytes over a 14-bit field. Otherwise the chunk is 512 bytes over a 13-bit field.
- R2: The chunk count equals the page data size divided by the chunk size, rounded down.
- R3: The raw strength is ((spare − 10) × 8) / (field_bits × chunk_count), rounded down. That value is then cleared to even and limited to a cap: 40 when cap_sel_i=0, 62 when cap_sel_i=1.
- R4: Let P = page × 8 − 80 and T = chunk_bytes × 8 + strength × field_bits. The chunk index is k = P / T. The marker offset is M = P − k × strength × field_bits. mark_byte_o = M >> 3 and mark_bit_o = M[2:0].
- R5: The result is an error (err_o=1) when the spare size is above the chunk size, the spare size is below 10, or the page size is below the chunk size. An error result reports zero on all numeric outputs.
- R6: The result is an error when P − k × T exceeds chunk_bytes × 8, meaning the marker lies in parity.
- R7: done_o is high for exactly one cycle per computation. The results and err_o hold until the next done. A start_i pulse while busy_o=1 is ignored.
- R8: After reset, done_o, err_o, busy_o and every numeric output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; inputs are latched when idle |
| page_bytes_i | input | 16 | Page data size in bytes |
| spare_bytes_i | input | 16 | Spare area size in bytes |
| cap_sel_i | input | 1 | Strength cap select: 0 gives 40, 1 gives 62 |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Invalid geometry |
| chunk_cnt_o | output | 8 | Chunks per page |
| strength_o | output | 8 | Even correction strength per chunk |
| mark_byte_o | output | 16 | Marker byte offset in the logical buffer |
| mark_bit_o | output | 3 | Marker bit within that byte |

## Verification
A table of geometries drives the main function. It includes pages of one, four and eight chunks, which separate the chunk-count path from the marker chunk index. It includes spare sizes whose raw strength is odd and even, so the rounding is observable. One spare size lands just past 512 bytes to exercise the field and chunk switch. Some rows sit above both caps with cap_sel_i toggled, and those show the limit alone moving the marker offset. Error rows cover an oversized spare, a short spare, a short page, and an odd page size whose marker falls in a parity field. Directed runs then check the reset values, the done pulse width, output hold, and a start issued while busy.

// File: rtl/ecc_geom_pkg.sv
package ecc_geom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNT,
    ST_STR,
    ST_MARK,
    ST_FIN
  } geom_st_e;
endpackage

// File: rtl/ecc_geom_div.sv
module ecc_geom_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    rem_sh, diff;
  logic          ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    diff   = rem_sh - {1'b0, dvs_q};
    ge     = !diff[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? diff[W-1:0] : rem_sh[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q;

  // R2: every quotient the sequencer consumes comes with a proper remainder
  p_rem_below_divisor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < dvs_q));
endmodule

// File: rtl/ecc_geom_strength.sv
module ecc_geom_strength #(
  parameter int W      = 32,
  parameter int STR_W  = 8,
  parameter int CAP_LO = 40,
  parameter int CAP_HI = 62
) (
  input  logic [W-1:0]     raw_i,
  input  logic             cap_sel_i,
  output logic [STR_W-1:0] str_o
);
  logic [W-1:0] even, cap;

  always_comb begin
    even  = {raw_i[W-1:1], 1'b0};
    cap   = cap_sel_i ? W'(CAP_HI) : W'(CAP_LO);
    str_o = (even > cap) ? STR_W'(cap) : STR_W'(even);
  end
endmodule

// File: rtl/ecc_geom_calc.sv
module ecc_geom_calc
  import ecc_geom_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int DIV_W      = 32,
  parameter int CHUNK_LG   = 9,
  parameter int META_BYTES = 10,
  parameter int GF_BASE    = 13,
  parameter int CAP_LO     = 40,
  parameter int CAP_HI     = 62,
  parameter int STR_W      = 8,
  localparam int CNT_W     = PAGE_W - CHUNK_LG + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_bytes_i,
  input  logic [PAGE_W-1:0] spare_bytes_i,
  input  logic              cap_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  chunk_cnt_o,
  output logic [STR_W-1:0]  strength_o,
  output logic [PAGE_W-1:0] mark_byte_o,
  output logic [2:0]        mark_bit_o
);
  localparam logic [DIV_W-1:0] BASE_D = DIV_W'(1 << CHUNK_LG);
  localparam logic [DIV_W-1:0] META_D = DIV_W'(META_BYTES);
  localparam logic [DIV_W-1:0] GF_D   = DIV_W'(GF_BASE);
  localparam int MW = PAGE_W + 3;

  geom_st_e          st_q;
  logic [PAGE_W-1:0] page_q, spare_q;
  logic              cap_q, wide_q, bad_q;
  logic [DIV_W-1:0]  ecc_q, div_a_q, div_b_q;
  logic              div_go_q;
  logic [MW-1:0]     mark_q;
  logic [CNT_W-1:0]  cnt_q, cnt_o_q;
  logic [STR_W-1:0]  str_q, str_o_q;
  logic [PAGE_W-1:0] byte_q;
  logic [2:0]        bit_q;
  logic              done_q, err_q;

  logic             div_done;
  logic [DIV_W-1:0] div_quo, div_rem;
  logic [STR_W-1:0] str_lim;

  logic             wide_in, bad_in;
  logic [DIV_W-1:0] page_in_d, spare_in_d, chunk_in_d;
  logic [DIV_W-1:0] chunk_d, chunk_bits_d, gf_d, ecc_new_d;

  ecc_geom_div #(.W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (div_go_q),
    .dividend_i (div_a_q),
    .divisor_i  (div_b_q),
    .done_o     (div_done),
    .quot_o     (div_quo),
    .rem_o      (div_rem)
  );

  ecc_geom_strength #(
    .W(DIV_W), .STR_W(STR_W), .CAP_LO(CAP_LO), .CAP_HI(CAP_HI)
  ) u_str (
    .raw_i     (div_quo),
    .cap_sel_i (cap_q),
    .str_o     (str_lim)
  );

  always_comb begin
    page_in_d    = DIV_W'(page_bytes_i);
    spare_in_d   = DIV_W'(spare_bytes_i);
    wide_in      = spare_in_d > BASE_D;
    chunk_in_d   = wide_in ? (BASE_D << 1) : BASE_D;
    bad_in       = (spare_in_d > chunk_in_d) || (spare_in_d < META_D) ||
                   (page_in_d < chunk_in_d);
    chunk_d      = wide_q ? (BASE_D << 1) : BASE_D;
    chunk_bits_d = chunk_d << 3;
    gf_d         = wide_q ? GF_D + DIV_W'(1) : GF_D;
    ecc_new_d    = DIV_W'(str_lim) * gf_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      page_q   <= '0;
      spare_q  <= '0;
      cap_q    <= 1'b0;
      wide_q   <= 1'b0;
      bad_q    <= 1'b0;
      ecc_q    <= '0;
      div_a_q  <= '0;
      div_b_q  <= '0;
      div_go_q <= 1'b0;
      mark_q   <= '0;
      cnt_q    <= '0;
      str_q    <= '0;
      cnt_o_q  <= '0;
      str_o_q  <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          page_q  <= page_bytes_i;
          spare_q <= spare_bytes_i;
          cap_q   <= cap_sel_i;
          wide_q  <= wide_in;
          if (bad_in) begin
            bad_q <= 1'b1;
            st_q  <= ST_FIN;
          end else begin
            div_go_q <= 1'b1;
            div_a_q  <= page_in_d;
            div_b_q  <= chunk_in_d;
            st_q     <= ST_CNT;
          end
        end
        ST_CNT: if (div_done) begin
          cnt_q    <= CNT_W'(div_quo);
          div_go_q <= 1'b1;
          div_a_q  <= (DIV_W'(spare_q) - META_D) << 3;
          div_b_q  <= gf_d * div_quo;
          st_q     <= ST_STR;
        end
        ST_STR: if (div_done) begin
          str_q    <= str_lim;
          ecc_q    <= ecc_new_d;
          div_go_q <= 1'b1;
          div_a_q  <= (DIV_W'(page_q) << 3) - (META_D << 3);
          div_b_q  <= chunk_bits_d + ecc_new_d;
          st_q     <= ST_MARK;
        end
        ST_MARK: if (div_done) begin
          // marker inside the parity field of its chunk
          if (div_rem > chunk_bits_d) bad_q <= 1'b1;
          else mark_q <= MW'(div_a_q - div_quo * ecc_q);
          st_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          err_q   <= bad_q;
          cnt_o_q <= bad_q ? '0 : cnt_q;
          str_o_q <= bad_q ? '0 : str_q;
          byte_q  <= bad_q ? '0 : mark_q[MW-1:3];
          bit_q   <= bad_q ? '0 : mark_q[2:0];
          bad_q   <= 1'b0;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign chunk_cnt_o = cnt_o_q;
  assign strength_o  = str_o_q;
  assign mark_byte_o = byte_q;
  assign mark_bit_o  = bit_q;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable({err_o, chunk_cnt_o, strength_o, mark_byte_o, mark_bit_o}));

  p_strength_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (!strength_o[0] &&
      (strength_o <= (cap_q ? STR_W'(CAP_HI) : STR_W'(CAP_LO)))));

  p_err_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (chunk_cnt_o == '0 && strength_o == '0 &&
      mark_byte_o == '0 && mark_bit_o == '0));

  p_mark_in_page_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (mark_byte_o < page_q));

  p_idle_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/ecc_geom_calc_test.sv
module ecc_geom_calc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] page = '0, spare = '0;
  logic        sel = 1'b0;
  logic        busy, done, err;
  logic [7:0]  cnt, str;
  logic [15:0] mbyte;
  logic [2:0]  mbit;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc_geom_calc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .page_bytes_i(page), .spare_bytes_i(spare), .cap_sel_i(sel),
    .busy_o(busy), .done_o(done), .err_o(err),
    .chunk_cnt_o(cnt), .strength_o(str),
    .mark_byte_o(mbyte), .mark_bit_o(mbit)
  );

  typedef struct packed {
    int pg; int sp; bit cs; bit er; int ct; int st; int by; int bi;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2048,   64, 1'b0, 1'b0, 4,  8, 1999, 0},
    '{2048,  112, 1'b0, 1'b0, 4, 14, 1969, 6},
    '{4096,  224, 1'b0, 1'b0, 8, 16, 3904, 0},
    '{4096,  128, 1'b0, 1'b0, 8,  8, 3995, 0},
    '{ 512,  512, 1'b1, 1'b0, 1, 62,  502, 0},
    '{ 512,  512, 1'b0, 1'b0, 1, 40,  502, 0},
    '{8192,  744, 1'b1, 1'b0, 8, 52, 7545, 0},
    '{8192,  744, 1'b0, 1'b0, 8, 40, 7692, 0},
    '{1024,  513, 1'b0, 1'b0, 1, 40, 1014, 0},
    '{2048,   10, 1'b0, 1'b0, 4,  0, 2038, 0},
    '{16384, 1216, 1'b1, 1'b1, 0,  0,    0, 0},
    '{ 256,   16, 1'b0, 1'b1, 0,  0,    0, 0},
    '{2048,    9, 1'b0, 1'b1, 0,  0,    0, 0},
    '{4645,   40, 1'b0, 1'b1, 0,  0,    0, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic launch(input int pg, input int sp, input bit cs);
    @(negedge clk);
    page = 16'(pg); spare = 16'(sp); sel = cs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int n = 0; n < 400; n++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    bit got;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 busy after reset", int'(busy), 0);
    chk("R8 err after reset", int'(err), 0);
    chk("R8 outputs after reset", int'(cnt) + int'(str) + int'(mbyte) + int'(mbit), 0);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i].pg, VECS[i].sp, VECS[i].cs);
      wait_done(got);
      chk($sformatf("R7 done seen v%0d", i), int'(got), 1);
      chk($sformatf("R5 R6 err v%0d", i), int'(err), int'(VECS[i].er));
      chk($sformatf("R1 R2 chunks v%0d", i), int'(cnt), VECS[i].ct);
      chk($sformatf("R3 strength v%0d", i), int'(str), VECS[i].st);
      chk($sformatf("R4 mark byte v%0d", i), int'(mbyte), VECS[i].by);
      chk($sformatf("R4 mark bit v%0d", i), int'(mbit), VECS[i].bi);
      @(negedge clk);
      chk($sformatf("R7 done one cycle v%0d", i), int'(done), 0);
    end

    // R7: start while busy is ignored, results hold afterwards
    launch(2048, 112, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 busy mid run", int'(busy), 1);
    page = 16'd4096; spare = 16'd224; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    chk("R7 done after busy start", int'(got), 1);
    chk("R7 ignored start chunks", int'(cnt), 4);
    chk("R7 ignored start strength", int'(str), 14);
    chk("R7 ignored start byte", int'(mbyte), 1969);
    begin
      int extra = 0;
      for (int n = 0; n < 150; n++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R7 no second done", extra, 0);
    end
    chk("R7 hold byte", int'(mbyte), 1969);
    chk("R7 hold bit", int'(mbit), 6);
    chk("R7 idle", int'(busy), 0);

    // R5 error clears previous nonzero results
    launch(256, 16, 1'b0);
    wait_done(got);
    chk("R5 err flag", int'(err), 1);
    chk("R5 zeroed byte", int'(mbyte), 0);
    repeat (10) @(negedge clk);
    chk("R7 err held", int'(err), 1);

    summary();
  end
endmodule